// File: doc/BRIEF.md
# ECC Fault Reporting and Injection Controller

This block sits beside the read path of a nonvolatile memory array. On each array read it takes the ECC decoder's single-bit and double-bit detect results. It turns them into sticky status flags and interrupt requests. It also latches the address and data of the first real fault so that software can find the failing word.

Software controls the block through one configuration byte, an error interrupt enable byte and a write-1-to-clear status byte. These are reached through a small register port with a two-bit select. Two fault-injection bits make every array read report a fault. This lets interrupt handlers be tested without a damaged array. Injected faults never disturb the capture registers. A suppress bit hides single-bit faults completely. The configuration byte also gates a command-complete interrupt, driven by a flag from the command sequencer.

Top module: `ecc_fault_ctl`

## Requirements
- R1: Select 0 is the configuration byte: bit 7 enables the command interrupt, bit 4 suppresses single faults, bit 1 forces double faults and bit 0 forces single faults. It resets to 0x00.
- R2: Configuration bits 6, 5, 3 and 2 read 0 and ignore writes. Select 1 (bit 1 double-fault enable, bit 0 single-fault enable) and select 2 (bit 1 double flag, bit 0 single flag) read 0 in bits 7..2. Select 3 reads 0x00.
- R3: `irq_cmd` is high exactly when the command interrupt enable is 1 and `cmd_done` is 1.
- R4: While the suppress bit is 1, no read sets the single flag, whether the single fault is real or forced.
- R5: While force-double is 1, every array read sets the double flag.
- R6: While force-single is 1 and suppress is 0, every array read sets the single flag.
- R7: A read that reports a fault only because forcing is active leaves `cap_addr`, `cap_data` and `cap_dbl` unchanged.
- R8: Force bits stay set across any number of reads until software writes 0 to them.
- R9: Status flags are sticky. Writing 1 to a flag bit at select 2 clears it, writing 0 has no effect, and a set in the same cycle wins over the clear.
- R10: When a read has both a real double and a real single fault, only the double flag is set, and the capture records it as double (`cap_dbl`=1).
- R11: The first real reported fault loads address, data and kind. The capture is held until software clears the flag of the captured kind. The next real fault after that loads again.
- R12: `irq_sgl` and `irq_dbl` equal their flag ANDed with the matching enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 enables, 2 status, 3 none |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| cmd_done | input | 1 | Command-complete flag from the sequencer |
| arr_rd | input | 1 | Array read strobe, one per read |
| ecc_sgl | input | 1 | ECC single-bit detect for this read |
| ecc_dbl | input | 1 | ECC double-bit detect for this read |
| arr_addr | input | AW | Address of the read |
| arr_data | input | DW | Data of the read |
| irq_cmd | output | 1 | Command-complete interrupt |
| irq_sgl | output | 1 | Single-fault interrupt |
| irq_dbl | output | 1 | Double-fault interrupt |
| cap_addr | output | AW | Captured fault address |
| cap_data | output | DW | Captured fault data |
| cap_dbl | output | 1 | Captured fault was double-bit |

## Verification
The main function is driven by a table of reads. Each read combines a configuration byte with a pair of real detect inputs. Clean reads under forcing are set against real faults, which shows whether the capture follows real faults only. Real single faults under suppress, and forced single faults under suppress, show which control wins. A read with both real detects, and a force of one kind with a real fault of the other, show how the flags and the capture split. Directed sequences cover holding the capture against a second fault and releasing it by clearing the flag of the other kind or of the captured kind. They also cover persistence of the force bits, a status write of zero, and the command interrupt.

// File: rtl/ecc_fault_ctl.sv
module ecc_fault_ctl #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          cmd_done,
  input  logic          arr_rd,
  input  logic          ecc_sgl,
  input  logic          ecc_dbl,
  input  logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_data,
  output logic          irq_cmd,
  output logic          irq_sgl,
  output logic          irq_dbl,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_data,
  output logic          cap_dbl
);
  localparam logic [1:0] SEL_CFG = 2'd0;
  localparam logic [1:0] SEL_IEN = 2'd1;
  localparam logic [1:0] SEL_STS = 2'd2;

  logic cc_ie, ign_sf, frc_df, frc_sf;
  logic ie_df, ie_sf;
  logic flg_df, flg_sf;
  logic cap_valid;

  wire wr_cfg = reg_we && reg_sel == SEL_CFG;
  wire wr_ien = reg_we && reg_sel == SEL_IEN;
  wire wr_sts = reg_we && reg_sel == SEL_STS;

  wire real_df = arr_rd && ecc_dbl;
  wire real_sf = arr_rd && ecc_sgl && !ecc_dbl && !ign_sf;
  wire set_df  = real_df || (arr_rd && frc_df);
  wire set_sf  = real_sf || (arr_rd && frc_sf && !ign_sf);
  wire clr_df  = wr_sts && reg_wdata[1];
  wire clr_sf  = wr_sts && reg_wdata[0];

  wire cap_rel  = cap_valid && (cap_dbl ? clr_df : clr_sf);
  wire cap_load = (real_df || real_sf) && (!cap_valid || cap_rel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_ie  <= 1'b0;
      ign_sf <= 1'b0;
      frc_df <= 1'b0;
      frc_sf <= 1'b0;
    end else if (wr_cfg) begin
      cc_ie  <= reg_wdata[7];
      ign_sf <= reg_wdata[4];
      frc_df <= reg_wdata[1];
      frc_sf <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_df <= 1'b0;
      ie_sf <= 1'b0;
    end else if (wr_ien) begin
      ie_df <= reg_wdata[1];
      ie_sf <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_df <= 1'b0;
      flg_sf <= 1'b0;
    end else begin
      if (set_df)      flg_df <= 1'b1;
      else if (clr_df) flg_df <= 1'b0;
      if (set_sf)      flg_sf <= 1'b1;
      else if (clr_sf) flg_sf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_dbl   <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
    end else if (cap_load) begin
      cap_valid <= 1'b1;
      cap_dbl   <= real_df;
      cap_addr  <= arr_addr;
      cap_data  <= arr_data;
    end else if (cap_rel) begin
      cap_valid <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CFG: reg_rdata = {cc_ie, 2'b00, ign_sf, 2'b00, frc_df, frc_sf};
      SEL_IEN: reg_rdata = {6'd0, ie_df, ie_sf};
      SEL_STS: reg_rdata = {6'd0, flg_df, flg_sf};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq_cmd = cc_ie && cmd_done;
  assign irq_sgl = flg_sf && ie_sf;
  assign irq_dbl = flg_df && ie_df;
endmodule

module ecc_fault_ctl_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_sel,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          cmd_done,
  input logic          arr_rd,
  input logic          ecc_sgl,
  input logic          ecc_dbl,
  input logic          irq_cmd,
  input logic          irq_sgl,
  input logic          irq_dbl,
  input logic [AW-1:0] cap_addr,
  input logic [DW-1:0] cap_data,
  input logic          cap_dbl,
  input logic          ign_sf,
  input logic          frc_df,
  input logic          frc_sf,
  input logic          flg_df,
  input logic          flg_sf,
  input logic          cap_valid
);
  wire sts_wr = reg_we && reg_sel == 2'd2;

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == 2'd0 |-> (reg_rdata[6:5] == 2'b00 && reg_rdata[3:2] == 2'b00));

  assert_cmd_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_done |-> !irq_cmd);

  assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ign_sf && !flg_sf |=> !flg_sf);

  assert_force_dbl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd && frc_df |=> flg_df);

  assert_force_sgl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd && frc_sf && !ign_sf |=> flg_sf);

  assert_forced_nocap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd && !ecc_sgl && !ecc_dbl |=> ($stable(cap_addr) && $stable(cap_data)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flg_df && !(sts_wr && reg_wdata[1]) |=> flg_df);

  assert_both_dbl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd && ecc_dbl && ecc_sgl && !cap_valid |=> cap_dbl);

  assert_cap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && !(sts_wr && (cap_dbl ? reg_wdata[1] : reg_wdata[0]))
    |=> ($stable(cap_addr) && $stable(cap_data) && $stable(cap_dbl)));

  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !flg_sf |-> !irq_sgl);

  assert_irq_gate_dbl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !flg_df |-> !irq_dbl);

  assert_force_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frc_df && !(reg_we && reg_sel == 2'd0) |=> frc_df);
endmodule

bind ecc_fault_ctl ecc_fault_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_done(cmd_done),
  .arr_rd(arr_rd), .ecc_sgl(ecc_sgl), .ecc_dbl(ecc_dbl),
  .irq_cmd(irq_cmd), .irq_sgl(irq_sgl), .irq_dbl(irq_dbl),
  .cap_addr(cap_addr), .cap_data(cap_data), .cap_dbl(cap_dbl),
  .ign_sf(ign_sf), .frc_df(frc_df), .frc_sf(frc_sf),
  .flg_df(flg_df), .flg_sf(flg_sf), .cap_valid(cap_valid)
);

// File: tb/ecc_fault_ctl_bench.sv
module ecc_fault_ctl_bench;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [7:0]    reg_wdata = 8'h00;
  logic [7:0]    reg_rdata;
  logic          cmd_done = 1'b0;
  logic          arr_rd = 1'b0;
  logic          ecc_sgl = 1'b0;
  logic          ecc_dbl = 1'b0;
  logic [AW-1:0] arr_addr = '0;
  logic [DW-1:0] arr_data = '0;
  logic          irq_cmd, irq_sgl, irq_dbl, cap_dbl;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ecc_fault_ctl #(.AW(AW), .DW(DW)) u_ecc_fault_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_done(cmd_done),
    .arr_rd(arr_rd), .ecc_sgl(ecc_sgl), .ecc_dbl(ecc_dbl),
    .arr_addr(arr_addr), .arr_data(arr_data), .irq_cmd(irq_cmd),
    .irq_sgl(irq_sgl), .irq_dbl(irq_dbl), .cap_addr(cap_addr),
    .cap_data(cap_data), .cap_dbl(cap_dbl)
  );

  // {cfg[7:0], ecc_sgl, ecc_dbl, expected {dbl,sgl} flags, capture expected}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    {8'h00, 1'b0, 1'b0, 2'b00, 1'b0},
    {8'h00, 1'b1, 1'b0, 2'b01, 1'b1},
    {8'h00, 1'b0, 1'b1, 2'b10, 1'b1},
    {8'h00, 1'b1, 1'b1, 2'b10, 1'b1},
    {8'h10, 1'b1, 1'b0, 2'b00, 1'b0},
    {8'h01, 1'b0, 1'b0, 2'b01, 1'b0},
    {8'h02, 1'b0, 1'b0, 2'b10, 1'b0},
    {8'h03, 1'b0, 1'b0, 2'b11, 1'b0},
    {8'h11, 1'b0, 1'b0, 2'b00, 1'b0},
    {8'h02, 1'b1, 1'b0, 2'b11, 1'b1},
    {8'h01, 1'b0, 1'b1, 2'b11, 1'b1}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic arr_read(input logic s, input logic db, input logic [AW-1:0] a, input logic [DW-1:0] dd);
    @(negedge clk);
    arr_rd = 1'b1; ecc_sgl = s; ecc_dbl = db; arr_addr = a; arr_data = dd;
    @(negedge clk);
    arr_rd = 1'b0; ecc_sgl = 1'b0; ecc_dbl = 1'b0;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rd(2'd0, r); check("R1 reset config", r, 8'h00);
    rd(2'd1, r); check("R2 reset enables", r, 8'h00);
    rd(2'd2, r); check("R9 reset status", r, 8'h00);
    check("R12 reset irqs", {irq_cmd, irq_sgl, irq_dbl}, 3'b000);
    rst_n = 1'b1;

    // R1 / R2: write all ones and read back implemented bits only
    wr(2'd0, 8'hFF); rd(2'd0, r); check("R1 R2 config readback", r, 8'h93);
    wr(2'd1, 8'hFF); rd(2'd1, r); check("R2 enable readback", r, 8'h03);
    rd(2'd3, r); check("R2 unused select", r, 8'h00);

    // R3 command interrupt
    wr(2'd0, 8'h00); cmd_done = 1'b1; #1;
    check("R3 cmd irq disabled", irq_cmd, 1'b0);
    wr(2'd0, 8'h80); #1;
    check("R3 cmd irq enabled", irq_cmd, 1'b1);
    cmd_done = 1'b0; #1;
    check("R3 cmd irq follows flag", irq_cmd, 1'b0);

    // Table walk: R4 R5 R6 R7 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'(16'h1000 + i);
      d = 32'hA500_0000 + DW'(i);
      wr(2'd2, 8'h03);
      wr(2'd0, VEC[i][12:5]);
      arr_read(VEC[i][4], VEC[i][3], a, d);
      rd(2'd2, r);
      check($sformatf("R4 R5 R6 R10 vector %0d flags", i), r, {6'd0, VEC[i][2:1]});
      check($sformatf("R12 vector %0d irqs", i), {irq_dbl, irq_sgl}, VEC[i][2:1]);
      if (VEC[i][0]) begin
        check($sformatf("R11 vector %0d cap addr", i), cap_addr, a);
        check($sformatf("R11 vector %0d cap data", i), cap_data, d);
        check($sformatf("R10 vector %0d cap kind", i), cap_dbl, VEC[i][3]);
      end
    end

    // R7: forced read with no real fault leaves an empty capture untouched
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h00);
    arr_read(1'b1, 1'b0, 16'h2222, 32'h2222_0000);
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h03);
    arr_read(1'b0, 1'b0, 16'h3333, 32'h3333_0000);
    check("R7 forced read keeps addr", cap_addr, 16'h2222);
    check("R7 forced read keeps data", cap_data, 32'h2222_0000);

    // R8: force bits survive reads
    arr_read(1'b0, 1'b0, 16'h3334, 32'h0);
    rd(2'd0, r); check("R8 force bits persist", r, 8'h03);
    wr(2'd2, 8'h03);
    arr_read(1'b0, 1'b0, 16'h3335, 32'h0);
    rd(2'd2, r); check("R8 force acts again", r, 8'h03);

    // R9: sticky, write 0 no effect, partial clear
    wr(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    wr(2'd2, 8'h00);
    rd(2'd2, r); check("R9 sticky and zero write", r, 8'h03);
    wr(2'd2, 8'h02);
    rd(2'd2, r); check("R9 clear double only", r, 8'h01);
    // R9: set wins over clear in the same cycle
    wr(2'd2, 8'h03);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h02;
    arr_rd = 1'b1; ecc_dbl = 1'b1; arr_addr = 16'h4444; arr_data = 32'h4444_0000;
    @(negedge clk);
    reg_we = 1'b0; arr_rd = 1'b0; ecc_dbl = 1'b0;
    rd(2'd2, r); check("R9 set beats clear", r, 8'h02);

    // R11: hold against later fault, release by clearing captured kind
    wr(2'd2, 8'h03);
    arr_read(1'b1, 1'b0, 16'h5555, 32'h5555_0000);
    arr_read(1'b0, 1'b1, 16'h6666, 32'h6666_0000);
    check("R11 hold first addr", cap_addr, 16'h5555);
    check("R11 hold first kind", cap_dbl, 1'b0);
    wr(2'd2, 8'h02);
    arr_read(1'b0, 1'b1, 16'h7777, 32'h7777_0000);
    check("R11 other kind clear keeps", cap_addr, 16'h5555);
    wr(2'd2, 8'h01);
    arr_read(1'b0, 1'b1, 16'h8888, 32'h8888_0000);
    check("R11 reload addr", cap_addr, 16'h8888);
    check("R11 reload data", cap_data, 32'h8888_0000);
    check("R11 reload kind", cap_dbl, 1'b1);

    // R12: enables gate the interrupts
    wr(2'd1, 8'h00);
    rd(2'd2, r); check("R12 flags still set", r[1], 1'b1);
    check("R12 irq off when disabled", {irq_dbl, irq_sgl}, 2'b00);
    wr(2'd1, 8'h02);
    check("R12 dbl irq enabled", irq_dbl, 1'b1);

    finish_run();
  end
endmodule